// File: doc/BRIEF.md
# Multichannel Summed-Threshold Spike Detector

This block watches a small neighbourhood of recording sites for neural spikes. On every accepted sample tick it takes one signed, already band-pass-filtered sample from each of seven neighbouring channels and adds them into one combined value. Because a spike appears on all sites under a neuron at the same moment while the noise on each site is largely independent, the sum raises the spike above the noise before any decision is made.

The noise level of the combined value is tracked as the mean of its squares over a window of 2^WIN_LOG2 accepted samples. The mean of the filtered signal is taken as zero, so no mean is subtracted, and the divide is a right shift. A spike is flagged when the combined value is negative and its square is larger than the squared multiplier times the variance. This is the same as crossing minus multiplier times sigma, without taking a square root. The multiplier magnitude is a plain input: 2 is the usual setting and 1 is allowed for a looser detector with more false events. A refractory count stops one spike from being reported twice.

Samples enter on a valid/ready stream. The block never applies back-pressure once it is out of reset: `in_ready` is low while reset is applied and high from the first clock after it. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high. The bus contents do not matter while `in_valid` is low. The detect pulse and the variance estimate are plain outputs with no handshake.

Top module: `spk_sumthr_top`

## Requirements
- R1: The value under test is the two's-complement sum of the seven channel samples. Channel c occupies bits [c*SAMPLE_W +: SAMPLE_W] of `ch_data`.
- R2: A sample whose combined sum is zero or positive never raises `detect`, however large it is.
- R3: `var_est` equals the floor of the sum of the squared combined values over one window, divided by 2^WIN_LOG2. Only accepted samples count.
- R4: `var_est` changes only on the edge that accepts the last sample of a window. The windows follow one another with no gaps, and the new value is visible in the following cycle.
- R5: The comparison is strict. A sample with sum s < 0 and s*s equal to m*m*var_est does not detect, and one with s*s greater than m*m*var_est does.
- R6: `thr_mult` is the unsigned multiplier magnitude m, giving a threshold of minus m sigma. The value 1 gives a lower threshold than the default 2, so a sample that misses at 2 can detect at 1.
- R7: No detect occurs until the first window after reset has completed, including on the sample that completes it.
- R8: `detect` is high for exactly one clock, in the cycle after the accepting edge. After a detect, the next REFRACT_LEN accepted samples cannot detect.
- R9: While `in_valid` is low, the inputs change neither `detect`, `var_est` nor the refractory count.
- R10: A synchronous, active-high `rst` clears the variance, the window accumulator and the refractory state, and holds `in_ready` low. The detector is inhibited again until a new window completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample bus holds a tick |
| in_ready | output | 1 | Block accepts samples (high whenever out of reset) |
| ch_data | input | NUM_CH*SAMPLE_W | Seven signed samples, channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| thr_mult | input | MULT_W | Threshold multiplier magnitude m |
| detect | output | 1 | One-clock spike pulse |
| var_est | output | 2*(SAMPLE_W+clog2(NUM_CH)) | Current variance estimate of the sum |

## Verification
The assertions take for granted that `thr_mult` is held steady while a sample is being accepted, and that REFRACT_LEN is at least one. The one-clock pulse property relies on that refractory gap. They also assume that `rst` is asserted for at least one edge before any sample arrives. The stimulus changes `thr_mult` only between samples, on the falling edge. It keeps the channel values inside the signed sample range, and it applies reset at the start and once more part way through the run.

// File: rtl/spk_sumthr_pkg.sv
package spk_sumthr_pkg;
  function automatic int sum_width(input int sample_w, input int num_ch);
    return sample_w + $clog2(num_ch);
  endfunction

  function automatic int sq_width(input int sample_w, input int num_ch);
    return 2 * sum_width(sample_w, num_ch);
  endfunction
endpackage

// File: rtl/spk_chan_adder.sv
module spk_chan_adder #(
  parameter int SAMPLE_W = 12,
  parameter int NUM_CH   = 7,
  localparam int SUM_W   = spk_sumthr_pkg::sum_width(SAMPLE_W, NUM_CH),
  localparam int SQ_W    = 2 * SUM_W
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_data,
  output logic signed [SUM_W-1:0]    sum,
  output logic [SQ_W-1:0]            sq
);
  logic signed [SUM_W-1:0] ext [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ext
    logic signed [SAMPLE_W-1:0] raw;
    assign raw    = ch_data[c*SAMPLE_W +: SAMPLE_W];
    assign ext[c] = SUM_W'(raw);
  end

  always_comb begin
    sum = '0;
    for (int c = 0; c < NUM_CH; c++) sum = sum + ext[c];
  end

  logic signed [SQ_W-1:0] sum_w, sq_s;
  assign sum_w = SQ_W'(sum);
  assign sq_s  = sum_w * sum_w;
  assign sq    = $unsigned(sq_s);
endmodule

// File: rtl/spk_var_est.sv
module spk_var_est #(
  parameter int SQ_W     = 30,
  parameter int WIN_LOG2 = 4,
  localparam int ACC_W   = SQ_W + WIN_LOG2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [SQ_W-1:0] sq,
  output logic [SQ_W-1:0] var_q,
  output logic            armed
);
  logic [ACC_W-1:0]    acc, acc_nxt;
  logic [WIN_LOG2-1:0] cnt;
  logic                last;

  assign acc_nxt = acc + ACC_W'(sq);
  assign last    = &cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      cnt   <= '0;
      var_q <= '0;
      armed <= 1'b0;
    end else if (fire) begin
      cnt <= cnt + 1'b1;
      if (last) begin
        var_q <= acc_nxt[ACC_W-1:WIN_LOG2];
        acc   <= '0;
        armed <= 1'b1;
      end else begin
        acc <= acc_nxt;
      end
    end
  end

  // R4
  var_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(fire && last) |=> $stable(var_q));
  // R7
  arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);
endmodule

// File: rtl/spk_thr_cmp.sv
module spk_thr_cmp #(
  parameter int SUM_W       = 15,
  parameter int SQ_W        = 30,
  parameter int MULT_W      = 3,
  parameter int REFRACT_LEN = 4,
  localparam int PROD_W     = SQ_W + 2*MULT_W,
  localparam int REFR_W     = $clog2(REFRACT_LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fire,
  input  logic                    armed,
  input  logic signed [SUM_W-1:0] sum,
  input  logic [SQ_W-1:0]         sq,
  input  logic [SQ_W-1:0]         var_q,
  input  logic [MULT_W-1:0]       mult,
  output logic                    detect
);
  logic [2*MULT_W-1:0] m2;
  logic [PROD_W-1:0]   limit;
  logic [REFR_W-1:0]   refr;
  logic                hit, over;

  assign m2    = (2*MULT_W)'(mult) * (2*MULT_W)'(mult);
  assign limit = PROD_W'(m2) * PROD_W'(var_q);
  assign over  = PROD_W'(sq) > limit;
  assign hit   = fire && armed && sum[SUM_W-1] && over && (refr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      detect <= 1'b0;
      refr   <= '0;
    end else begin
      detect <= hit;
      if (hit)                      refr <= REFR_W'(REFRACT_LEN);
      else if (fire && refr != '0)  refr <= refr - 1'b1;
    end
  end

  // R2
  neg_only_chk: assert property (@(posedge clk) disable iff (rst)
    detect |-> $past(sum) < 0);
  // R7
  armed_first_chk: assert property (@(posedge clk) disable iff (rst)
    detect |-> $past(armed));
  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    detect |=> !detect);
  // R8
  refr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && refr != '0) |=> !detect);
  // R9
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    detect |-> $past(fire));
endmodule

// File: rtl/spk_sumthr_top.sv
module spk_sumthr_top #(
  parameter int SAMPLE_W    = 12,
  parameter int NUM_CH      = 7,
  parameter int WIN_LOG2    = 4,
  parameter int MULT_W      = 3,
  parameter int REFRACT_LEN = 4,
  localparam int SUM_W      = spk_sumthr_pkg::sum_width(SAMPLE_W, NUM_CH),
  localparam int SQ_W       = spk_sumthr_pkg::sq_width(SAMPLE_W, NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_data,
  input  logic [MULT_W-1:0]          thr_mult,
  output logic                       detect,
  output logic [SQ_W-1:0]            var_est
);
  logic                    ready_q, fire, armed;
  logic signed [SUM_W-1:0] sum;
  logic [SQ_W-1:0]         sq;

  always_ff @(posedge clk) ready_q <= !rst;
  assign in_ready = ready_q;
  assign fire     = in_valid && ready_q;

  spk_chan_adder #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) adder_i (
    .ch_data(ch_data), .sum(sum), .sq(sq));

  spk_var_est #(.SQ_W(SQ_W), .WIN_LOG2(WIN_LOG2)) var_i (
    .clk(clk), .rst(rst), .fire(fire), .sq(sq), .var_q(var_est), .armed(armed));

  spk_thr_cmp #(.SUM_W(SUM_W), .SQ_W(SQ_W), .MULT_W(MULT_W),
                .REFRACT_LEN(REFRACT_LEN)) cmp_i (
    .clk(clk), .rst(rst), .fire(fire), .armed(armed), .sum(sum), .sq(sq),
    .var_q(var_est), .mult(thr_mult), .detect(detect));

  // R10
  ready_rst_chk: assert property (@(posedge clk)
    rst |=> !in_ready && !detect && var_est == '0);
endmodule

// File: tb/spk_sumthr_tb.sv
module spk_sumthr_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 12, NC = 7, WL = 4, MW = 3, RL = 4;
  localparam int QW = 2 * (SW + 3);

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic in_ready, detect;
  logic [NC*SW-1:0] ch_data = '0;
  logic [MW-1:0] thr_mult = 3'd2;
  logic [QW-1:0] var_est;

  int total = 0, bad = 0;
  longint m_acc = 0, m_var = 0;
  int m_cnt = 0, m_refr = 0;
  bit m_armed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spk_sumthr_top #(.SAMPLE_W(SW), .NUM_CH(NC), .WIN_LOG2(WL), .MULT_W(MW),
                   .REFRACT_LEN(RL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .ch_data(ch_data), .thr_mult(thr_mult), .detect(detect), .var_est(var_est));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_var = 0; m_cnt = 0; m_refr = 0; m_armed = 0;
  endtask

  // sends one accepted sample, checks detect/var against the requirement model
  task automatic send(input int v [7], input string tag, output bit det);
    longint s = 0, m;
    bit exp_det;
    for (int c = 0; c < NC; c++) begin
      s += v[c];
      ch_data[c*SW +: SW] = SW'(v[c]);
    end
    m = longint'(thr_mult);
    exp_det = m_armed && (s < 0) && (s*s > m*m*m_var) && (m_refr == 0);
    if (exp_det) m_refr = RL; else if (m_refr > 0) m_refr--;
    m_acc += s*s;
    if (m_cnt == (1<<WL) - 1) begin
      m_var = m_acc >>> WL; m_acc = 0; m_armed = 1;
    end
    m_cnt = (m_cnt + 1) % (1<<WL);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    det = detect;
    check(detect == exp_det, {tag, " detect"}, longint'(detect), longint'(exp_det));
    check(var_est == QW'(m_var), {tag, " var"}, longint'(var_est), m_var);
  endtask

  task automatic send_all(input int x, input string tag, output bit det);
    send('{x, x, x, x, x, x, x}, tag, det);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R10 ready in reset", longint'(in_ready), 0);
    check(detect == 1'b0, "R10 detect in reset", longint'(detect), 0);
    check(var_est == '0, "R10 var in reset", longint'(var_est), 0);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R10 ready after reset", longint'(in_ready), 1);
  endtask

  task automatic t_first_window();
    bit d;
    for (int i = 0; i < 16; i++) begin
      send('{-5, 3, -1, 0, -4, 2, -9}, "R7 inhibited", d);
      if (i == 7) check(var_est == '0, "R4 mid window", longint'(var_est), 0);
    end
    check(var_est == QW'(196), "R1 R3 first variance", longint'(var_est), 196);
  endtask

  task automatic t_threshold();
    bit d;
    send_all(-4, "R5 equal no detect", d);
    check(d == 1'b0, "R5 equal", longint'(d), 0);
    send('{-5, -4, -4, -4, -4, -4, -4}, "R5 above", d);
    check(d == 1'b1, "R5 above detects", longint'(d), 1);
    for (int i = 0; i < RL; i++) begin
      send_all(-50, "R8 refractory", d);
      check(d == 1'b0, "R8 blocked", longint'(d), 0);
    end
    send_all(-50, "R8 after refractory", d);
    check(d == 1'b1, "R8 rearmed", longint'(d), 1);
    @(negedge clk);
    check(detect == 1'b0, "R8 one clock pulse", longint'(detect), 0);
  endtask

  task automatic t_stall();
    bit d;
    longint v0 = longint'(var_est);
    ch_data = {NC{SW'(-300)}};
    in_valid = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(detect == 1'b0, "R9 idle detect", longint'(detect), 0);
      check(longint'(var_est) == v0, "R9 idle var", longint'(var_est), v0);
    end
    for (int i = 0; i < RL; i++) send_all(0, "R9 drain refractory", d);
    send_all(50, "R2 positive", d);
    check(d == 1'b0, "R2 positive no detect", longint'(d), 0);
  endtask

  task automatic t_mult1();
    bit d;
    longint r = 0;
    while (m_cnt != 0) send_all(0, "R4 fill window", d);
    check(m_var > 0, "R3 variance nonzero", m_var, 1);
    while ((r+1)*(r+1) <= m_var) r++;
    thr_mult = 3'd2;
    send('{-int'(r+1), 0, 0, 0, 0, 0, 0}, "R6 mult two", d);
    check(d == 1'b0, "R6 misses at two", longint'(d), 0);
    thr_mult = 3'd1;
    send('{-int'(r+1), 0, 0, 0, 0, 0, 0}, "R6 mult one", d);
    check(d == 1'b1, "R6 hits at one", longint'(d), 1);
    thr_mult = 3'd2;
  endtask

  task automatic t_mid_reset();
    bit d;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check(var_est == '0, "R10 var cleared", longint'(var_est), 0);
    @(negedge clk);
    send_all(-200, "R10 R7 reinhibited", d);
    check(d == 1'b0, "R10 no detect after reset", longint'(d), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_window();
        t_threshold();
        t_stall();
        t_mult1();
        t_mid_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule